// File: doc/BRIEF.md
# H-Bridge Gate Control and Fault Logic

This block is the digital core of a full-bridge motor driver. Each half-bridge, or leg, has a high-side switch and a low-side switch. The block turns two direction inputs into gate enables for both legs. A PWM input chops only the low-side switches, which sets motor speed. Per-leg enable inputs can take a leg out of service.

Comparator flags report four conditions: supply out of range, high-side over-temperature, low-side saturation, and cooling below the thermal reset point. The block uses them to shut the bridge down and to latch faulty legs off. A faulted leg raises a pull-down request for its shared open-drain diagnostic/enable pad. The leg stays off until its own direction input rises again.

Every time a leg swaps from one switch to the other, both of its switches stay off for a parameterised number of cycles. The block also enables the current-sense output only while exactly one high side conducts.

Top module: `hbridge_ctrl`

## Requirements
- R1: For each leg, a synchronized direction input of 1 turns on the high side and 0 turns on the low side. Direction inputs (a,b) give: (1,1) both outputs high, (1,0) A high and B low, (0,1) A low and B high, (0,0) both outputs low.
- R2: While PWM is low, both low-side gate outputs are 0 whatever the direction inputs are. The high-side outputs still follow the direction inputs. When PWM returns high, the low sides follow the current direction inputs again.
- R3: An enable input held at 0 turns off both switches of its leg and does not raise that leg's diagnostic output. The other leg keeps working.
- R4: Over-temperature or saturation on a leg sets that leg's fault latch. The leg's gates go off and its diagnostic output goes to 1, while the other leg keeps working.
- R5: A latched fault clears only on a 0-to-1 transition of that leg's direction input, and only while the leg's over-temperature and saturation flags are both inactive. A 1-to-0 transition does not clear it.
- R6: After an over-temperature event, a fault on that leg does not clear until the thermal-reset (cooled) flag has been seen high.
- R7: While undervoltage or overvoltage is flagged, all four gate outputs are 0. Normal drive resumes once both flags drop.
- R8: When a leg changes from one switch to the other, both of its switches stay off for DEAD_CYC+1 clock cycles. Neither switch of a leg turns on in the cycle right after the other one was on.
- R9: The current-sense enable is 1 exactly when one high side is on. It is 0 in both brake modes, when both legs are off, and when a single faulted leg leaves no high side on.
- R10: During reset all gate, diagnostic and current-sense outputs are 0. Every asynchronous input passes through a two-flop synchronizer, so a change reaches the gates three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_a_i | input | 1 | Leg A direction (1 selects high side) |
| dir_b_i | input | 1 | Leg B direction (1 selects high side) |
| pwm_i | input | 1 | Low-side chopping input |
| en_a_i | input | 1 | Leg A enable, read from the shared pad |
| en_b_i | input | 1 | Leg B enable, read from the shared pad |
| uv_i | input | 1 | Supply undervoltage flag |
| ov_i | input | 1 | Supply overvoltage flag |
| ot_a_i | input | 1 | Leg A high-side over-temperature flag |
| ot_b_i | input | 1 | Leg B high-side over-temperature flag |
| cool_i | input | 1 | Junction cooled below thermal reset point |
| sat_a_i | input | 1 | Leg A low-side saturation flag |
| sat_b_i | input | 1 | Leg B low-side saturation flag |
| hs_a_o | output | 1 | Leg A high-side gate enable |
| ls_a_o | output | 1 | Leg A low-side gate enable |
| hs_b_o | output | 1 | Leg B high-side gate enable |
| ls_b_o | output | 1 | Leg B low-side gate enable |
| diag_a_o | output | 1 | Leg A pad pull-down request (fault) |
| diag_b_o | output | 1 | Leg B pad pull-down request (fault) |
| cs_en_o | output | 1 | Current-sense output enable |

## Verification
The assertions rely on the synchronizer depth being fixed at two stages. Each input is judged by the value it had three edges before an output sample (two for PWM). A fault that clears is tied to the direction input having risen four and three edges earlier. The stimulus changes each input only on the falling clock edge and holds it for many cycles, so every input value is registered cleanly. Fault flags are pulsed for several cycles, and the cooled flag is raised only after over-temperature has dropped.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_state_e;

    typedef struct packed {
        logic dir;
        logic en;
        logic ot;
        logic sat;
    } leg_in_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  leg_in_t in_s,
    input  logic    pwm_s,
    input  logic    cool_s,
    input  logic    supply_ok,
    output logic    hs_o,
    output logic    ls_o,
    output logic    diag_o
);
    localparam int CNT_W = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);

    typedef struct packed {
        leg_state_e       cur;
        logic [CNT_W-1:0] cnt;
        logic             fault;
        logic             tlock;
        logic             dir_prev;
    } leg_reg_t;

    leg_reg_t   r_d, r_q;
    leg_state_e target;
    logic       dir_rise, en_ok;

    always_comb begin
        r_d          = r_q;
        dir_rise     = in_s.dir & ~r_q.dir_prev;
        r_d.dir_prev = in_s.dir;
        // thermal lock stays until the cooled flag is seen
        r_d.tlock    = in_s.ot | (r_q.tlock & ~cool_s);
        r_d.fault    = in_s.ot | in_s.sat | (r_q.fault & ~(dir_rise & ~r_q.tlock));
        // pad is read as an enable only while no pull-down is requested
        en_ok        = in_s.en & ~r_q.fault;

        if (!supply_ok || r_d.fault || !en_ok) target = LEG_OFF;
        else if (in_s.dir)                     target = LEG_HIGH;
        else                                   target = LEG_LOW;

        if (target != r_q.cur) begin
            if (r_q.cur != LEG_OFF) begin
                r_d.cur = LEG_OFF;
                r_d.cnt = CNT_W'(DEAD_CYC);
            end else if (r_q.cnt != '0) begin
                r_d.cnt = r_q.cnt - 1'b1;
            end else begin
                r_d.cur = target;
            end
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hs_o   = (r_q.cur == LEG_HIGH);
    assign ls_o   = (r_q.cur == LEG_LOW) & pwm_s;
    assign diag_o = r_q.fault;
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int DEAD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_a_i,
    input  logic dir_b_i,
    input  logic pwm_i,
    input  logic en_a_i,
    input  logic en_b_i,
    input  logic uv_i,
    input  logic ov_i,
    input  logic ot_a_i,
    input  logic ot_b_i,
    input  logic cool_i,
    input  logic sat_a_i,
    input  logic sat_b_i,
    output logic hs_a_o,
    output logic ls_a_o,
    output logic hs_b_o,
    output logic ls_b_o,
    output logic diag_a_o,
    output logic diag_b_o,
    output logic cs_en_o
);
    localparam int NLEG  = 2;
    localparam int LEG_W = $bits(leg_in_t);

    leg_in_t [NLEG-1:0] leg_raw, leg_s;
    logic    [NLEG-1:0] hs, ls, diag;
    logic    [3:0]      shr_s;
    logic               pwm_s, uv_s, ov_s, cool_s, supply_ok;

    assign leg_raw[0] = '{dir: dir_a_i, en: en_a_i, ot: ot_a_i, sat: sat_a_i};
    assign leg_raw[1] = '{dir: dir_b_i, en: en_b_i, ot: ot_b_i, sat: sat_b_i};

    hb_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync_shared (
        .clk(clk), .rst_n(rst_n),
        .d({pwm_i, uv_i, ov_i, cool_i}),
        .q(shr_s)
    );
    assign {pwm_s, uv_s, ov_s, cool_s} = shr_s;
    assign supply_ok = ~uv_s & ~ov_s;

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        hb_sync #(.W(LEG_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n),
            .d(leg_raw[g]),
            .q(leg_s[g])
        );
        hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk(clk), .rst_n(rst_n),
            .in_s(leg_s[g]), .pwm_s(pwm_s), .cool_s(cool_s),
            .supply_ok(supply_ok),
            .hs_o(hs[g]), .ls_o(ls[g]), .diag_o(diag[g])
        );
    end

    assign hs_a_o   = hs[0];
    assign ls_a_o   = ls[0];
    assign hs_b_o   = hs[1];
    assign ls_b_o   = ls[1];
    assign diag_a_o = diag[0];
    assign diag_b_o = diag[1];
    assign cs_en_o  = hs[0] ^ hs[1];
endmodule

// File: rtl/hb_ctrl_chk.sv
module hb_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic dir_a_i,
    input logic dir_b_i,
    input logic pwm_i,
    input logic en_a_i,
    input logic uv_i,
    input logic ov_i,
    input logic hs_a_o,
    input logic ls_a_o,
    input logic hs_b_o,
    input logic ls_b_o,
    input logic diag_a_o,
    input logic diag_b_o,
    input logic cs_en_o
);
    AST_PWM_LOW_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwm_i, 2) |-> (!ls_a_o && !ls_b_o)); // R2
    AST_EN_LOW_LEG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_a_i, 3) |-> (!hs_a_o && !ls_a_o)); // R3
    AST_FAULT_LEG_A_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        diag_a_o |-> (!hs_a_o && !ls_a_o)); // R4
    AST_FAULT_LEG_B_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        diag_b_o |-> (!hs_b_o && !ls_b_o)); // R4
    AST_CLEAR_NEEDS_RISE_A: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(diag_a_o) |-> ($past(dir_a_i, 3) && !$past(dir_a_i, 4))); // R5
    AST_CLEAR_NEEDS_RISE_B: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(diag_b_o) |-> ($past(dir_b_i, 3) && !$past(dir_b_i, 4))); // R5
    AST_SUPPLY_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(uv_i, 3) || $past(ov_i, 3)) |-> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o)); // R7
    AST_GAP_LS_TO_HS_A: assert property (@(posedge clk) disable iff (!rst_n)
        ls_a_o |=> !hs_a_o); // R8
    AST_GAP_HS_TO_LS_A: assert property (@(posedge clk) disable iff (!rst_n)
        hs_a_o |=> !ls_a_o); // R8
    AST_GAP_LS_TO_HS_B: assert property (@(posedge clk) disable iff (!rst_n)
        ls_b_o |=> !hs_b_o); // R8
    AST_GAP_HS_TO_LS_B: assert property (@(posedge clk) disable iff (!rst_n)
        hs_b_o |=> !ls_b_o); // R8
    AST_CS_OFF_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        cs_en_o |-> !($past(uv_i, 3) || $past(ov_i, 3))); // R9
endmodule

bind hbridge_ctrl hb_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dir_a_i(dir_a_i), .dir_b_i(dir_b_i),
    .pwm_i(pwm_i), .en_a_i(en_a_i), .uv_i(uv_i), .ov_i(ov_i),
    .hs_a_o(hs_a_o), .ls_a_o(ls_a_o), .hs_b_o(hs_b_o), .ls_b_o(ls_b_o),
    .diag_a_o(diag_a_o), .diag_b_o(diag_b_o), .cs_en_o(cs_en_o)
);

// File: tb/tb_hbridge_ctrl.sv
`timescale 1ns/1ps
module tb_hbridge_ctrl;
    localparam int DT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_a = 0, dir_b = 0, pwm = 0, en_a = 0, en_b = 0;
    logic uv = 0, ov = 0, ot_a = 0, ot_b = 0, cool = 1, sat_a = 0, sat_b = 0;
    logic hs_a, ls_a, hs_b, ls_b, diag_a, diag_b, cs_en;
    int   n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    hbridge_ctrl #(.DEAD_CYC(DT), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n),
        .dir_a_i(dir_a), .dir_b_i(dir_b), .pwm_i(pwm), .en_a_i(en_a), .en_b_i(en_b),
        .uv_i(uv), .ov_i(ov), .ot_a_i(ot_a), .ot_b_i(ot_b), .cool_i(cool),
        .sat_a_i(sat_a), .sat_b_i(sat_b),
        .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b),
        .diag_a_o(diag_a), .diag_b_o(diag_b), .cs_en_o(cs_en)
    );

    // {req, stim{dir_a,dir_b,pwm,en_a,en_b,uv,ov}, exp{hs_a,ls_a,hs_b,ls_b,cs,diag_a,diag_b}}
    localparam logic [17:0] VEC [11] = '{
        {4'd1,  7'b1111100, 7'b1010000},  // R1 brake high
        {4'd1,  7'b1011100, 7'b1001100},  // R1 A high, B low
        {4'd9,  7'b0111100, 7'b0110100},  // R9 (and R1) A low, B high, sense on
        {4'd1,  7'b0011100, 7'b0101000},  // R1 brake low
        {4'd2,  7'b1001100, 7'b1000100},  // R2 pwm low keeps high side
        {4'd2,  7'b0001100, 7'b0000000},  // R2 pwm low kills low sides
        {4'd3,  7'b1010100, 7'b0001000},  // R3 leg A disabled
        {4'd3,  7'b0111000, 7'b0100000},  // R3 leg B disabled
        {4'd7,  7'b1111110, 7'b0000000},  // R7 undervoltage
        {4'd7,  7'b1011101, 7'b0000000},  // R7 overvoltage
        {4'd7,  7'b1011100, 7'b1001100}   // R7 resume
    };

    function automatic logic [6:0] outs();
        return {hs_a, ls_a, hs_b, ls_b, cs_en, diag_a, diag_b};
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        check("R10 reset outputs", outs(), 7'b0000000);
        rst_n = 1'b1;
        wait_n(2);

        for (int i = 0; i < 11; i++) begin
            {dir_a, dir_b, pwm, en_a, en_b, uv, ov} = VEC[i][13:7];
            wait_n(20);
            check($sformatf("R%0d vector %0d", VEC[i][17:14], i), outs(), VEC[i][6:0]);
        end

        // R10: latency of three edges through the synchronizers
        uv = 1'b1;
        wait_n(2);
        check("R10 two edges, still driving", outs(), 7'b1001100);
        wait_n(1);
        check("R10 third edge, shut down", outs(), 7'b0000000);
        uv = 1'b0;
        wait_n(20);

        // R8: dead time on leg A going high side -> low side
        begin
            int off_cnt = 0;
            dir_a = 1'b0;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (!hs_a && !ls_a) off_cnt++;
                if (ls_a) break;
            end
            check("R8 dead-time off cycles", 7'(off_cnt), 7'(DT + 1));
        end
        dir_a = 1'b1;
        wait_n(20);

        // R4: saturation on leg A, leg B keeps working
        sat_a = 1'b1;
        wait_n(5);
        sat_a = 1'b0;
        wait_n(10);
        check("R4 leg A faulted, B runs", outs(), 7'b0001010);
        dir_a = 1'b0;
        wait_n(20);
        check("R5 falling edge keeps latch", outs(), 7'b0001010);
        dir_a = 1'b1;
        wait_n(20);
        check("R5 rising edge clears", outs(), 7'b1001100);

        // R5 with flag still active on leg B
        sat_b = 1'b1;
        wait_n(10);
        check("R9 sense with one leg open", outs(), 7'b1000101);
        dir_b = 1'b1;
        wait_n(20);
        check("R5 rise ignored while flag held", outs(), 7'b1000101);
        sat_b = 1'b0;
        dir_b = 1'b0;
        wait_n(10);
        dir_b = 1'b1;
        wait_n(20);
        check("R5 clears after flag drops", outs(), 7'b1010000);
        dir_b = 1'b0;
        wait_n(20);

        // R6: thermal hysteresis on leg A
        cool = 1'b0;
        ot_a = 1'b1;
        wait_n(5);
        ot_a = 1'b0;
        wait_n(10);
        check("R6 over-temperature latches", outs(), 7'b0001010);
        dir_a = 1'b0;
        wait_n(10);
        dir_a = 1'b1;
        wait_n(20);
        check("R6 no restart before cooling", outs(), 7'b0001010);
        cool = 1'b1;
        wait_n(10);
        dir_a = 1'b0;
        wait_n(10);
        dir_a = 1'b1;
        wait_n(20);
        check("R6 restart after cooling", outs(), 7'b1001100);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule